// File: doc/BRIEF.md
# Four-Channel Signed PWM/PDM Bridge Driver

This block drives four motor bridges. Each channel has an 11-bit duty value and two outputs, one for each direction of drive ("up" and "down"). A control word for each channel sets the duty. It also sets a steering bit that picks which of the two outputs carries the pulse, and one inversion bit for each output. A channel whose duty is zero stops modulating. Its two inversion bits then act as plain static levels on its two pins.

All channels share one free-running period counter. Its wrap is exported as a one-cycle strobe, which neighbouring blocks can use as a time base. In pulse-width mode the active output is high while the counter is below the duty. One mode bit, carried only in channel 0's word, switches all four channels to pulse-density mode. In that mode each channel adds its duty into an accumulator on every clock, and the carry out of the accumulator is the pulse.

Control words are written into a pending copy. They reach the active copy only at the counter wrap, so a period is never disturbed part-way through. An external disable request clears a registered output-enable, which a pad ring can use for tristate control.

Top module: `pwm_pdm_driver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `up_o`/`dn_o` bit, `ovf_o` and `oe_o` is 0, and all control words read as zero.
- R2: The period counter counts 0..2047 and wraps. `ovf_o` is high for exactly one cycle every 2048 cycles. In the `ovf_o` cycle the outputs show the decision for counter value 2047.
- R3: In pulse-width mode, a channel with a nonzero duty D (word bits 10..0) holds its active output high for exactly D of the 2048 cycles of a period, in one contiguous run that begins with counter value 0.
- R4: Word bit 15 steers the pulse. At 1 the pulse appears on `up_o` and `dn_o` is held at its idle level. At 0 the pulse appears on `dn_o` and `up_o` is held at its idle level.
- R5: With a nonzero duty, word bit 12 inverts `up_o` and word bit 13 inverts `dn_o`. This applies to the pulsed output and to the output held at its idle level.
- R6: With a zero duty field, `up_o` equals word bit 12 and `dn_o` equals word bit 13, constant over the whole period.
- R7: Bit 14 of channel 0's word puts all four channels in pulse-density mode. The pulse is the carry of an 11-bit accumulator that adds D every clock, giving D separate one-cycle pulses per 2048 cycles when D < 1024. Bit 14 of channels 1..3 has no effect.
- R8: A written word becomes active only at the next counter wrap. Outputs before that wrap follow the previous word. This includes a write made in the wrap cycle itself.
- R9: `oe_o` equals the inverse of `drv_off` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (40 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for a channel control word |
| cfg_ch | input | 2 | Channel selected by the write |
| cfg_word | input | 16 | Control word: duty 10..0, invert-up 12, invert-down 13, density mode 14 (channel 0 only), steering 15 |
| drv_off | input | 1 | External request to release the drivers |
| up_o | output | 4 | "Up" output of each channel |
| dn_o | output | 4 | "Down" output of each channel |
| ovf_o | output | 1 | One-cycle period wrap strobe |
| oe_o | output | 1 | Registered output enable |

## Verification
The hardest situation to reach is the handover at the wrap. That is the instant where a pending word replaces the active one, where a write can land in the wrap cycle itself, and where the density bit of channel 0 changes the mode of all four channels at once. The stimulus waits on `ovf_o` and writes words at known offsets into a period, including the cycle just after a wrap. A behavioural model compares every output on every clock. Counts of high cycles and rising edges over aligned windows then tell pulse-width from pulse-density operation, and show that bit 14 on the other channels is ignored.

// File: rtl/pwm_pdm_pkg.sv
package pwm_pdm_pkg;
  localparam int WORD_W      = 16;
  localparam int INV_UP_BIT  = 12;
  localparam int INV_DN_BIT  = 13;
  localparam int DENSITY_BIT = 14;
  localparam int STEER_BIT   = 15;
endpackage

// File: rtl/pdm_period_ctr.sv
module pdm_period_ctr #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  assign wrap_o = &cnt_q;
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      ovf_q <= wrap_o;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> cnt_q == '0); // R2
endmodule

// File: rtl/pdm_channel.sv
module pdm_channel
  import pwm_pdm_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              density_i,
  output logic              up_o,
  output logic              dn_o
);
  logic [WORD_W-1:0] pend_q, act_q;
  logic [CNT_W-1:0]  acc_q;
  logic [CNT_W:0]    sum;
  logic [CNT_W-1:0]  duty;
  logic              pulse, up_n, dn_n, up_q, dn_q;
  logic              unused_bits;

  assign duty        = act_q[CNT_W-1:0];
  assign sum         = {1'b0, acc_q} + {1'b0, duty};
  assign unused_bits = ^act_q[DENSITY_BIT:CNT_W];

  always_comb begin
    pulse = density_i ? sum[CNT_W] : (cnt_i < duty);
    if (duty == '0) begin
      up_n = act_q[INV_UP_BIT];
      dn_n = act_q[INV_DN_BIT];
    end else begin
      up_n = (act_q[STEER_BIT] & pulse) ^ act_q[INV_UP_BIT];
      dn_n = (~act_q[STEER_BIT] & pulse) ^ act_q[INV_DN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
      acc_q  <= '0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      if (cfg_we) pend_q <= cfg_word;
      if (load_i) act_q <= pend_q;
      acc_q <= sum[CNT_W-1:0];
      up_q  <= up_n;
      dn_q  <= dn_n;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(act_q)); // R8
  AST_STEER_UP: assert property (@(posedge clk) disable iff (rst)
    (duty != '0) && act_q[STEER_BIT] |=> dn_q == $past(act_q[INV_DN_BIT])); // R4
  AST_STEER_DN: assert property (@(posedge clk) disable iff (rst)
    (duty != '0) && !act_q[STEER_BIT] |=> up_q == $past(act_q[INV_UP_BIT])); // R4
  AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (rst)
    duty == '0 |=> up_q == $past(act_q[INV_UP_BIT]) && dn_q == $past(act_q[INV_DN_BIT])); // R6
endmodule

// File: rtl/pwm_pdm_driver.sv
module pwm_pdm_driver
  import pwm_pdm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 11,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              drv_off,
  output logic [NCH-1:0]    up_o,
  output logic [NCH-1:0]    dn_o,
  output logic              ovf_o,
  output logic              oe_o
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             dens_pend_q, dens_act_q, oe_q;

  pdm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt),
    .wrap_o (wrap),
    .ovf_o  (ovf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dens_pend_q <= 1'b0;
      dens_act_q  <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      if (cfg_wr && cfg_ch == '0) dens_pend_q <= cfg_word[DENSITY_BIT];
      if (wrap) dens_act_q <= dens_pend_q;
      oe_q <= ~drv_off;
    end
  end

  assign oe_o = oe_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pdm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_wr && (cfg_ch == CH_W'(i))),
      .cfg_word  (cfg_word),
      .load_i    (wrap),
      .cnt_i     (cnt),
      .density_i (dens_act_q),
      .up_o      (up_o[i]),
      .dn_o      (dn_o[i])
    );
  end

  AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(dens_act_q)); // R8
  AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_off) |=> !oe_o); // R9
endmodule

// File: tb/test_pwm_pdm_driver.sv
module test_pwm_pdm_driver;
  localparam int CLK_PERIOD = 25;
  localparam int NCH = 4;
  localparam int PER = 2048;

  logic clk = 1'b0, rst = 1'b1, cfg_wr = 1'b0, drv_off = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [15:0] cfg_word = '0;
  logic [NCH-1:0] up_o, dn_o;
  logic ovf_o, oe_o;

  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit chk_en = 0;

  pwm_pdm_driver i_pwm_pdm_driver (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_word(cfg_word),
    .drv_off(drv_off), .up_o(up_o), .dn_o(dn_o), .ovf_o(ovf_o), .oe_o(oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [15:0] m_pend [NCH];
  logic [15:0] m_act  [NCH];
  int m_acc [NCH];
  int m_cnt;
  bit m_dens_p, m_dens_a;
  logic [NCH-1:0] e_up = '0, e_dn = '0;
  logic e_ovf = 1'b0, e_oe = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin m_pend[c] = '0; m_act[c] = '0; m_acc[c] = 0; end
      m_cnt = 0; m_dens_p = 0; m_dens_a = 0;
      e_up = '0; e_dn = '0; e_ovf = 0; e_oe = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int d; bit p;
        d = int'(m_act[c][10:0]);
        p = m_dens_a ? ((m_acc[c] + d) >= PER) : (m_cnt < d);
        if (d == 0) begin
          e_up[c] = m_act[c][12]; e_dn[c] = m_act[c][13];
        end else begin
          e_up[c] = (m_act[c][15] ? p : 1'b0) ^ m_act[c][12];
          e_dn[c] = (m_act[c][15] ? 1'b0 : p) ^ m_act[c][13];
        end
        m_acc[c] = (m_acc[c] + d) % PER;
      end
      e_ovf = (m_cnt == PER - 1);
      e_oe  = !drv_off;
      if (m_cnt == PER - 1) begin
        for (int c = 0; c < NCH; c++) m_act[c] = m_pend[c];
        m_dens_a = m_dens_p;
      end
      if (cfg_wr) begin
        m_pend[cfg_ch] = cfg_word;
        if (cfg_ch == 0) m_dens_p = cfg_word[14];
      end
      m_cnt = (m_cnt + 1) % PER;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      tests++;
      if (up_o !== e_up || dn_o !== e_dn || ovf_o !== e_ovf || oe_o !== e_oe) begin
        fails++;
        $display("FAIL %s cycle %0d: up=%b dn=%b ovf=%b oe=%b expected up=%b dn=%b ovf=%b oe=%b",
                 cur_req, cycles, up_o, dn_o, ovf_o, oe_o, e_up, e_dn, e_ovf, e_oe);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_word(input int ch, input logic [15:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ch = 2'(ch); cfg_word = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_ovf();
    do @(negedge clk); while (!ovf_o);
  endtask

  // aligned window of one period: highs and rising edges of one output
  task automatic measure(input int ch, input bit use_dn, output int highs, output int rises);
    bit prev, v;
    wait_ovf();
    prev = use_dn ? dn_o[ch] : up_o[ch];
    highs = 0; rises = 0;
    repeat (PER) begin
      @(negedge clk);
      v = use_dn ? dn_o[ch] : up_o[ch];
      highs += int'(v);
      if (v && !prev) rises++;
      prev = v;
    end
  endtask

  initial begin : watchdog
    wait (cycles > 190000);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int h, r, t0;
    repeat (4) @(negedge clk);
    check("R1", int'({up_o, dn_o, ovf_o, oe_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'({up_o, dn_o, ovf_o}), 0);
    chk_en = 1;

    cur_req = "R2";
    wait_ovf(); t0 = cycles;
    wait_ovf(); check("R2", cycles - t0, PER);

    cur_req = "R3";
    write_word(0, 16'h8064);   // steer up, duty 100
    write_word(1, 16'h07FF);   // steer down, duty 2047
    write_word(2, 16'h9001);   // steer up, invert up, duty 1
    write_word(3, 16'h1000);   // duty 0, static up=1 dn=0
    wait_ovf();
    measure(0, 0, h, r); check("R3", h, 100); check("R3", r, 1);
    measure(0, 1, h, r); check("R4", h, 0);
    measure(1, 1, h, r); check("R3", h, 2047);
    measure(1, 0, h, r); check("R4", h, 0);
    measure(2, 0, h, r); check("R5", h, 2047);
    measure(2, 1, h, r); check("R5", h, 0);
    measure(3, 0, h, r); check("R6", h, PER);
    measure(3, 1, h, r); check("R6", h, 0);

    cur_req = "R8";
    wait_ovf();
    write_word(0, 16'h81F4);   // duty 500, pending until next wrap
    measure(0, 0, h, r); check("R8", h, 500);
    wait_ovf();
    @(negedge clk); @(negedge clk);
    cfg_wr = 1'b1; cfg_ch = 2'd3; cfg_word = 16'h2000;
    @(negedge clk); cfg_wr = 1'b0;

    cur_req = "R7";
    write_word(0, 16'hC064);   // density mode, duty 100
    write_word(1, 16'h812C);   // steer up, duty 300
    wait_ovf();
    measure(0, 0, h, r); check("R7", h, 100); check("R7", r, 100);
    measure(1, 0, h, r); check("R7", h, 300); check("R7", r, 300);
    measure(3, 1, h, r); check("R6", h, PER);

    write_word(0, 16'h8064);   // density off
    write_word(1, 16'hC12C);   // bit 14 on channel 1 only
    wait_ovf();
    measure(1, 0, h, r); check("R7", h, 300); check("R7", r, 1);

    cur_req = "R9";
    @(negedge clk); drv_off = 1'b1;
    @(negedge clk); check("R9", int'(oe_o), 0);
    drv_off = 1'b0;
    @(negedge clk); check("R9", int'(oe_o), 1);
    repeat (20) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule